// File: doc/BRIEF.md
# Preemptive Write Buffer for a Slow-Write Nonvolatile Array

This block sits between a cache controller and a nonvolatile data array whose reads finish in one cycle but whose writes need a long pulse. Writes from the controller are parked in a small buffer and trickle out to the array in the background. Reads go to the array at once, or they are answered from the buffer when the line is still parked there. A read never waits behind a background write. The write loses the array for that cycle and is then either paused, so it keeps its progress, or cancelled, so it starts over. A build parameter selects which of the two.

Repeated writes to a line that is already buffered update the same entry, so they cost one array write. If such a write lands on the entry whose pulse is already running, that entry is written a second time with the newer data. When every entry is occupied, the block stops accepting anything that would need a new entry or the array. This lets the oldest write retire even if the controller keeps issuing reads.

Top module: `nvm_wr_buffer`

## Requirements
- R1: After reset the buffer is empty: `req_ready` is 1, and `arr_re`, `arr_we`, `arr_wlast`, `arr_wbusy` and `rsp_valid` are 0.
- R2: An accepted write that is not disturbed drives `arr_we` for exactly `WR_LAT` consecutive cycles, starting the cycle after acceptance, with `arr_wlast` high in the final one. The array stores the line in that final cycle.
- R3: A read that misses the buffer raises `arr_re` with `arr_addr` equal to the request address in its accept cycle. `rsp_valid` is high in the next cycle with `rsp_data` equal to the array contents.
- R4: A read whose address is held in the buffer is answered in the next cycle with the newest buffered data, and `arr_re` stays low.
- R5: In a cycle where a read miss is accepted, `arr_re` is 1 and `arr_we` is 0, even while a buffered write is mid-pulse.
- R6: In pause mode (`PREEMPT` = 0, the default) a preempted write resumes where it stopped, so it spends `WR_LAT` cycles on the array in total.
- R7: In cancel mode (`PREEMPT` = 1) a preempted write starts again, so its total is the cycles already spent plus `WR_LAT`.
- R8: Several writes to a buffered line that has not started share one entry and produce one array write carrying the last data.
- R9: A write to the line whose array pulse is in progress is accepted. After the running pulse ends, the line is written again with the newer data.
- R10: While all `DEPTH` entries are occupied, `req_ready` is 0 for a write to a new line and for a read miss, `arr_we` stays high, and a request to a buffered line is still accepted.
- R11: Buffered lines reach the array in the order in which they first entered the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Line address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| rsp_valid | output | 1 | Read data valid, one cycle after read acceptance |
| rsp_data | output | DW | Read data |
| arr_re | output | 1 | Array read strobe |
| arr_we | output | 1 | Array write pulse active in this cycle |
| arr_wlast | output | 1 | Final cycle of a write pulse; array commits the data |
| arr_addr | output | AW | Array address |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data, valid the cycle after `arr_re` |
| arr_wbusy | output | 1 | A write pulse has begun and not yet finished |

## Verification
On every cycle the assertions check several rules. A read strobe and a write pulse never share the array. A full buffer always drives a write pulse. A request is refused only when the buffer is full. A buffer hit never touches the array. Every response follows an accepted read, and occupancy never exceeds the depth. Some behaviour shows only in the bench's scenarios, which follow the array's contents over many cycles: the exact pulse length, the extra cycles a cancelled write costs compared with a paused one, the merging of repeated writes, the rewrite after a merge into the running entry, and the order in which lines are retired.

// File: rtl/nvwb_pkg.sv
package nvwb_pkg;
   // How a running array write reacts when a read takes the array
   typedef enum logic {
      PREEMPT_PAUSE  = 1'b0,
      PREEMPT_CANCEL = 1'b1
   } preempt_e;
endpackage

// File: rtl/nvwb_store.sv
// Line-addressed entry store: circular age order plus address match
module nvwb_store #(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] look_addr,
   input  logic          put,
   input  logic [DW-1:0] put_data,
   input  logic          take,
   output logic          hit,
   output logic [DW-1:0] hit_data,
   output logic          head_hit,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic [CW-1:0] occ
);
   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] match;
   logic [PW-1:0]    head_q, tail_q, hit_idx;
   logic [CW-1:0]    occ_q;
   logic             alloc;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = valid_q[i] && (addr_q[i] == look_addr);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = PW'(i);
      end
   end

   assign hit       = |match;
   assign hit_data  = data_q[hit_idx];
   assign head_hit  = match[head_q];
   assign head_addr = addr_q[head_q];
   assign head_data = data_q[head_q];
   assign alloc     = put && !hit;
   assign occ       = occ_q;
   assign full      = (occ_q == CW'(DEPTH));
   assign empty     = (occ_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         head_q  <= '0;
         tail_q  <= '0;
         occ_q   <= '0;
      end else begin
         if (alloc) begin
            valid_q[tail_q] <= 1'b1;
            tail_q          <= tail_q + PW'(1);
         end
         if (take) begin
            valid_q[head_q] <= 1'b0;
            head_q          <= head_q + PW'(1);
         end
         occ_q <= occ_q + CW'(alloc) - CW'(take);
      end
   end

   always_ff @(posedge clk) begin
      if (put) begin
         if (hit) begin
            data_q[hit_idx] <= put_data;
         end else begin
            addr_q[tail_q] <= look_addr;
            data_q[tail_q] <= put_data;
         end
      end
   end
endmodule

// File: rtl/nvwb_engine.sv
// Multi-cycle array write sequencer with read preemption
module nvwb_engine
   import nvwb_pkg::*;
#(
   parameter int       DW      = 16,
   parameter int       WR_LAT  = 10,
   parameter preempt_e PREEMPT = PREEMPT_PAUSE,
   localparam int      LW      = $clog2(WR_LAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pending,
   input  logic          rd_take,
   input  logic          head_touch,
   input  logic [DW-1:0] head_data,
   output logic          we,
   output logic          last,
   output logic          pop,
   output logic [DW-1:0] wdata,
   output logic          busy
);
   logic          act_q, rew_q, drop;
   logic [LW-1:0] rem_q;
   logic [DW-1:0] dat_q;

   if (PREEMPT == PREEMPT_CANCEL) begin : g_cancel
      assign drop = rd_take && act_q;
   end else begin : g_pause
      assign drop = 1'b0;
   end

   assign we    = pending && !rd_take;
   assign last  = we && (rem_q == LW'(1));
   assign pop   = last && !rew_q && !head_touch;
   assign wdata = act_q ? dat_q : head_data;
   assign busy  = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rew_q <= 1'b0;
         rem_q <= LW'(WR_LAT);
         dat_q <= '0;
      end else if (we) begin
         if (!act_q) dat_q <= head_data;
         if (last) begin
            act_q <= 1'b0;
            rew_q <= 1'b0;
            rem_q <= LW'(WR_LAT);
         end else begin
            act_q <= 1'b1;
            rem_q <= rem_q - LW'(1);
            if (head_touch) rew_q <= 1'b1;
         end
      end else if (drop) begin
         act_q <= 1'b0;
         rew_q <= 1'b0;
         rem_q <= LW'(WR_LAT);
      end
   end
endmodule

// File: rtl/nvwb_resp.sv
// Read response stage: forwarded buffer data or array data
module nvwb_resp #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_fire,
   input  logic          rd_hit,
   input  logic [DW-1:0] fwd_data,
   input  logic [DW-1:0] arr_rdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);
   logic          vld_q, hit_q;
   logic [DW-1:0] fwd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         hit_q <= 1'b0;
         fwd_q <= '0;
      end else begin
         vld_q <= rd_fire;
         hit_q <= rd_fire && rd_hit;
         if (rd_fire && rd_hit) fwd_q <= fwd_data;
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_data  = hit_q ? fwd_q : arr_rdata;
endmodule

// File: rtl/nvm_wr_buffer.sv
module nvm_wr_buffer
   import nvwb_pkg::*;
#(
   parameter int       AW      = 8,
   parameter int       DW      = 16,
   parameter int       DEPTH   = 8,
   parameter int       WR_LAT  = 10,
   parameter preempt_e PREEMPT = PREEMPT_PAUSE,
   localparam int      CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          arr_re,
   output logic          arr_we,
   output logic          arr_wlast,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] arr_wdata,
   input  logic [DW-1:0] arr_rdata,
   output logic          arr_wbusy
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("nvm_wr_buffer: DEPTH must be a power of two of at least 2");
   end
   if (WR_LAT < 2) begin : g_bad_lat
      $error("nvm_wr_buffer: WR_LAT must be at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("nvm_wr_buffer: AW and DW must be positive");
   end

   logic          hit, head_hit, full, empty;
   logic [DW-1:0] hit_data, head_data;
   logic [AW-1:0] head_addr;
   logic [CW-1:0] occ;
   logic          acc, put, rd_fire, rd_miss, head_touch, pop;

   assign req_ready  = !full || hit;
   assign acc        = req_valid && req_ready;
   assign put        = acc && req_write;
   assign rd_fire    = acc && !req_write;
   assign rd_miss    = rd_fire && !hit;
   assign head_touch = put && head_hit;

   nvwb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_addr (req_addr),
      .put       (put),
      .put_data  (req_wdata),
      .take      (pop),
      .hit       (hit),
      .hit_data  (hit_data),
      .head_hit  (head_hit),
      .full      (full),
      .empty     (empty),
      .head_addr (head_addr),
      .head_data (head_data),
      .occ       (occ)
   );

   nvwb_engine #(.DW(DW), .WR_LAT(WR_LAT), .PREEMPT(PREEMPT)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .pending    (!empty),
      .rd_take    (rd_miss),
      .head_touch (head_touch),
      .head_data  (head_data),
      .we         (arr_we),
      .last       (arr_wlast),
      .pop        (pop),
      .wdata      (arr_wdata),
      .busy       (arr_wbusy)
   );

   nvwb_resp #(.DW(DW)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (rd_fire),
      .rd_hit    (hit),
      .fwd_data  (hit_data),
      .arr_rdata (arr_rdata),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   assign arr_re   = rd_miss;
   assign arr_addr = rd_miss ? req_addr : head_addr;
endmodule

// File: rtl/nvm_wr_buffer_chk.sv
module nvm_wr_buffer_chk #(
   parameter int DEPTH = 8,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_write,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          arr_re,
   input logic          arr_we,
   input logic          arr_wlast,
   input logic          full,
   input logic          hit,
   input logic [CW-1:0] occ
);
   a_r5_read_owns_array: assert property (@(posedge clk) disable iff (!rst_n)
      arr_re |-> !arr_we);

   a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write && req_ready));

   a_r4_hit_skips_array: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && hit) |-> !arr_re);

   a_r10_refuse_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |-> full);

   a_r10_full_drains: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> arr_we);

   a_r10_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   a_r2_last_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wlast |-> arr_we);
endmodule

bind nvm_wr_buffer nvm_wr_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .arr_re    (arr_re),
   .arr_we    (arr_we),
   .arr_wlast (arr_wlast),
   .full      (full),
   .hit       (hit),
   .occ       (occ)
);

// File: tb/nvm_wr_buffer_bench.sv
`timescale 1ns/1ps
module nvm_wr_buffer_bench;
   localparam int AW = 6, DW = 12, DEPTH = 4, LAT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid, req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          req_ready, rsp_valid, arr_re, arr_we, arr_wlast, arr_wbusy;
   logic [DW-1:0] rsp_data, arr_wdata;
   logic [DW-1:0] arr_rdata = '0;
   logic [AW-1:0] arr_addr;

   logic          cx_ready, cx_rvld, cx_re, cx_we, cx_last, cx_busy;
   logic [DW-1:0] cx_rsp, cx_wdata;
   logic [DW-1:0] cx_rdata = '0;
   logic [AW-1:0] cx_addr;

   nvm_wr_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WR_LAT(LAT),
                   .PREEMPT(nvwb_pkg::PREEMPT_PAUSE)) u_nvm_wr_buffer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .arr_re(arr_re), .arr_we(arr_we),
      .arr_wlast(arr_wlast), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .arr_rdata(arr_rdata), .arr_wbusy(arr_wbusy));

   nvm_wr_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WR_LAT(LAT),
                   .PREEMPT(nvwb_pkg::PREEMPT_CANCEL)) u_nvm_wr_buffer_cx (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(cx_ready),
      .rsp_valid(cx_rvld), .rsp_data(cx_rsp), .arr_re(cx_re), .arr_we(cx_we),
      .arr_wlast(cx_last), .arr_addr(cx_addr), .arr_wdata(cx_wdata),
      .arr_rdata(cx_rdata), .arr_wbusy(cx_busy));

   function automatic logic [DW-1:0] seed(input int a);
      return DW'(a * 37 + 5);
   endfunction

   // array model for the pause instance, with a log of committed writes
   logic [DW-1:0] mem [64];
   logic [63:0]   written;
   logic [AW-1:0] log_a [64];
   logic [DW-1:0] log_d [64];
   int nlog = 0, we_n = 0, we_n_cx = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         written <= '0;
      end else begin
         if (arr_re) arr_rdata <= written[arr_addr] ? mem[arr_addr] : seed(int'(arr_addr));
         if (cx_re)  cx_rdata  <= seed(int'(cx_addr));
         if (arr_we) we_n <= we_n + 1;
         if (cx_we)  we_n_cx <= we_n_cx + 1;
         if (arr_we && arr_wlast) begin
            mem[arr_addr]     <= arr_wdata;
            written[arr_addr] <= 1'b1;
            if (nlog < 64) begin
               log_a[nlog] <= arr_addr;
               log_d[nlog] <= arr_wdata;
               nlog <= nlog + 1;
            end
         end
      end
   end

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic ck(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input int a, input int d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = DW'(d);
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
   endtask

   task automatic rd(input int a, output int d, output int re, output int vld);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      re = int'(arr_re);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      vld = int'(rsp_valid);
      d   = int'(rsp_data);
   endtask

   initial begin
      int d, re, vld, k, n0, wb0, wc0, cnt7;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      ck("R1 req_ready", int'(req_ready), 1);
      ck("R1 arr_we", int'(arr_we), 0);
      ck("R1 arr_re", int'(arr_re), 0);
      ck("R1 rsp_valid", int'(rsp_valid), 0);
      ck("R1 arr_wbusy", int'(arr_wbusy), 0);
      ck("R1 arr_wlast", int'(arr_wlast), 0);

      // R3 read miss served by the array next cycle
      rd(5, d, re, vld);
      ck("R3 arr_re", re, 1);
      ck("R3 rsp_valid", vld, 1);
      ck("R3 rsp_data", d, int'(seed(5)));

      // R2 undisturbed pulse length
      n0 = nlog; wb0 = we_n;
      wr(9, 'h199);
      ck("R2 pulse starts", int'(arr_we), 1);
      k = 1;
      while (!arr_wlast && k < 50) begin @(negedge clk); #1; k++; end
      ck("R2 cycles to last", k, LAT);
      idle(3);
      ck("R2 we cycles", we_n - wb0, LAT);
      ck("R2 commits", nlog - n0, 1);
      ck("R2 data", int'(mem[9]), 'h199);

      // R11 arrival order
      n0 = nlog;
      wr(1, 'h111); wr(2, 'h222); wr(3, 'h333);
      idle(3 * LAT + 4);
      ck("R11 commits", nlog - n0, 3);
      for (int i = 0; i < 3; i++) ck("R11 order", int'(log_a[n0 + i]), i + 1);

      // R4 forwarding and R9 merge into the running entry
      n0 = nlog;
      wr(7, 'h0AB);
      rd(7, d, re, vld);
      ck("R4 no array read", re, 0);
      ck("R4 data", d, 'h0AB);
      wr(7, 'h0CD);
      rd(7, d, re, vld);
      ck("R4 newest data", d, 'h0CD);
      ck("R4 rsp_valid", vld, 1);
      idle(3 * LAT + 4);
      cnt7 = 0;
      for (int i = n0; i < nlog; i++) if (log_a[i] == AW'(7)) cnt7++;
      ck("R9 two array writes", cnt7, 2);
      ck("R9 first data", int'(log_d[n0]), 'h0AB);
      ck("R9 final data", int'(mem[7]), 'h0CD);

      // R8 merge into a waiting entry
      n0 = nlog;
      wr(10, 'h100); wr(20, 'h001); wr(20, 'h002);
      idle(3 * LAT + 4);
      ck("R8 commits", nlog - n0, 2);
      ck("R8 first line", int'(log_a[n0]), 10);
      ck("R8 merged line", int'(log_a[n0 + 1]), 20);
      ck("R8 merged data", int'(log_d[n0 + 1]), 'h002);

      // R5 R6 R7 read preempts a pulse after two cycles
      wb0 = we_n; wc0 = we_n_cx;
      wr(30, 'h030);
      idle(2);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(40);
      #1;
      ck("R5 arr_re", int'(arr_re), 1);
      ck("R5 arr_we held off", int'(arr_we), 0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      ck("R5 rsp_data", int'(rsp_data), int'(seed(40)));
      idle(3 * LAT);
      ck("R6 pause total cycles", we_n - wb0, LAT);
      ck("R7 cancel total cycles", we_n_cx - wc0, 2 + LAT);
      ck("R6 data", int'(mem[30]), 'h030);

      // R10 full buffer
      n0 = nlog;
      wr(50, 'h050); wr(51, 'h051); wr(52, 'h052); wr(53, 'h053);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(54); req_wdata = DW'('h054);
      #1;
      ck("R10 new line refused", int'(req_ready), 0);
      ck("R10 drain running", int'(arr_we), 1);
      req_addr = AW'(51); req_wdata = DW'('h5A5);
      #1;
      ck("R10 buffered line accepted", int'(req_ready), 1);
      @(negedge clk);
      req_write = 1'b0; req_addr = AW'(60);
      #1;
      ck("R10 read miss refused", int'(req_ready), 0);
      ck("R10 no array read", int'(arr_re), 0);
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      ck("R10 stalled read data", int'(rsp_data), int'(seed(60)));
      wr(54, 'h054);
      idle(6 * LAT);
      ck("R10 commits", nlog - n0, 5);
      for (int i = 0; i < 5; i++) ck("R11 full order", int'(log_a[n0 + i]), 50 + i);
      ck("R10 merged while full", int'(mem[51]), 'h5A5);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule